// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host end of a three-wire link to a 16-bit successive-approximation converter. A single-cycle `start` begins one conversion frame. The controller pulls the active-low select line down, toggles a data clock whose phases are a programmable number of system clocks long, and captures the converter's output on the rising clock edges. The converter spends its first five clock periods acquiring the input. It then drives one null bit, which must read low, followed by the result with the most significant bit first.

The host chooses how many result bits to read. When it asks for fewer than sixteen, the frame is cut short: select goes high right after the last wanted bit. The returned word is left-justified, with the unread low bits set to zero, and is reported together with the bit count actually used. After every frame, select stays high for a fixed recovery interval so the converter powers down. A new start is accepted only after that interval ends.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, and `busy`, `resultValid`, `nullErr` and `result` are all 0.
- R2: While a frame runs, every high phase and every low phase of `sclk` lasts exactly `clkDiv` system cycles. A `clkDiv` of 0 is treated as 1.
- R3: `csN` falls while `sclk` is low. The first rising `sclk` edge follows one full low phase (`clkDiv` cycles) later.
- R4: The bit sampled at the 6th rising edge is the null bit. Rising edges 7 onward carry the result MSB first, so edge 7 lands in `result[15]`. The word is two's complement and is passed through unchanged (for example, 0x8001 reads as 0x8001).
- R5: `nullErr` is 1 for a frame whose null bit was sampled high, and 0 otherwise. It stays valid alongside `result` until the next start.
- R6: `bitCount` is clamped to the range 1..16 and gives the effective count n. Exactly 6+n rising `sclk` edges occur while `csN` is low. `csN` rises on the falling edge that follows the n-th data bit, so `csN` is low for 2·clkDiv·(6+n) cycles.
- R7: When n is below 16, `result` holds the n bits in its top positions with the rest zero, and `resultBits` equals n.
- R8: `resultValid` is a one-cycle pulse. It appears in the first cycle in which `csN` is high again.
- R9: After `csN` rises, `sclk` stays low and `busy` stays high for two more `sclk` periods (4·clkDiv cycles), so a full 16-bit frame takes 24 clock periods.
- R10: A `start` that arrives while `busy` is high, whether mid-frame or during recovery, is ignored. It causes no second select fall and does not change the frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one frame when idle |
| clkDiv | input | DIV_W | System cycles per data-clock phase (0 acts as 1) |
| bitCount | input | 5 | Result bits to read (clamped to 1..16) |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low converter select |
| sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | Frame or recovery in progress |
| result | output | 16 | Left-justified two's complement result |
| resultBits | output | 5 | Number of bits held in `result` |
| nullErr | output | 1 | Null bit read high in last frame |
| resultValid | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with DIV_W = 4 and keeps the default 16-bit word, six lead edges and two recovery periods. A 4-bit divider lets the bench sweep the phase length from the 0-as-1 case up to the maximum of 15 within a short run. A bus-functional converter model drives a high value before the null slot, so a null or data capture taken one edge early or late shows up as a wrong error flag or a shifted word. Short reads of 14 and 3 bits and clamped counts of 0 and 20 exercise the truncation and clamping paths. Starts are injected both mid-frame and during the recovery interval.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int unsigned POS_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_TAIL,
    ST_GAP
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic             clearAll;
    logic             takeNull;
    logic             takeBit;
    logic [POS_W-1:0] bitPos;
    logic             finish;
  } rdStrobe_t;

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LEAD_EDGES  = 6,
  parameter int unsigned GAP_PERIODS = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [DIV_W-1:0]             clkDiv,
  input  logic [$clog2(DATA_W+1)-1:0]  bitCount,
  output logic                         csN,
  output logic                         sclk,
  output logic                         busy,
  output logic [$clog2(DATA_W+1)-1:0]  bitsUsed,
  output rdStrobe_t                    strb
);

  localparam int unsigned BITS_W = $clog2(DATA_W + 1);
  localparam int unsigned RISE_W = $clog2(LEAD_EDGES + DATA_W + 1);
  localparam int unsigned GAP_W  = $clog2(2 * GAP_PERIODS + 1);
  localparam logic [BITS_W-1:0] FULL_N   = BITS_W'(DATA_W);
  localparam logic [RISE_W-1:0] NULL_IDX = RISE_W'(LEAD_EDGES);
  localparam logic [RISE_W-1:0] TOP_IDX  = RISE_W'(DATA_W + LEAD_EDGES);
  localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(2 * GAP_PERIODS - 1);

  rdState_t          state;
  logic [DIV_W-1:0]  phaseCnt;
  logic [DIV_W-1:0]  divReg;
  logic [BITS_W-1:0] nbReg;
  logic [RISE_W-1:0] riseCnt;
  logic [GAP_W-1:0]  gapCnt;

  logic [DIV_W-1:0]  effDiv;
  logic [BITS_W-1:0] effBits;
  logic [RISE_W-1:0] riseNext;
  logic [RISE_W-1:0] lastRise;
  logic              phaseEnd;

  always_comb begin
    effDiv = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
    if (bitCount == '0)        effBits = BITS_W'(1);
    else if (bitCount > FULL_N) effBits = FULL_N;
    else                       effBits = bitCount;
    riseNext = riseCnt + 1'b1;
    lastRise = NULL_IDX + RISE_W'(nbReg);
    phaseEnd = (phaseCnt == '0);
  end

  always_comb begin
    strb          = '0;
    strb.clearAll = (state == ST_IDLE) && start;
    if (state == ST_ACTIVE && phaseEnd && !sclk) begin
      strb.takeNull = (riseNext == NULL_IDX);
      strb.takeBit  = (riseNext > NULL_IDX);
      strb.bitPos   = POS_W'(TOP_IDX - riseNext);
    end
    strb.finish = (state == ST_TAIL) && phaseEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      phaseCnt <= '0;
      divReg   <= DIV_W'(1);
      nbReg    <= FULL_N;
      riseCnt  <= '0;
      gapCnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            divReg   <= effDiv;
            nbReg    <= effBits;
            phaseCnt <= effDiv - 1'b1;
            riseCnt  <= '0;
            csN      <= 1'b0;
            sclk     <= 1'b0;
            state    <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (phaseEnd) begin
            phaseCnt <= divReg - 1'b1;
            sclk     <= ~sclk;
            if (!sclk) begin
              riseCnt <= riseNext;
              if (riseNext == lastRise) state <= ST_TAIL;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_TAIL: begin
          if (phaseEnd) begin
            sclk     <= 1'b0;
            csN      <= 1'b1;
            phaseCnt <= divReg - 1'b1;
            gapCnt   <= GAP_LAST;
            state    <= ST_GAP;
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (phaseEnd) begin
            if (gapCnt == '0) begin
              state <= ST_IDLE;
            end else begin
              gapCnt   <= gapCnt - 1'b1;
              phaseCnt <= divReg - 1'b1;
            end
          end else begin
            phaseCnt <= phaseCnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign bitsUsed = nbReg;

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && !phaseEnd) |=> $stable(sclk)); // R2
  AST_CS_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csN) |-> !sclk); // R3
  AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nbReg >= BITS_W'(1) && nbReg <= FULL_N)); // R6
  AST_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    csN |-> !sclk); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(divReg) && $stable(nbReg))); // R10

endmodule

// File: rtl/adc_rd_dpath.sv
module adc_rd_dpath
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  rdStrobe_t         strb,
  output logic [DATA_W-1:0] result,
  output logic              nullErr,
  output logic              resultValid
);

  localparam int unsigned IDX_W = $clog2(DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      nullErr     <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.finish;
      if (strb.clearAll) begin
        result  <= '0;
        nullErr <= 1'b0;
      end
      if (strb.takeNull) nullErr <= sdi;
      if (strb.takeBit)  result[strb.bitPos[IDX_W-1:0]] <= sdi;
    end
  end

  AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid); // R8

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LEAD_EDGES  = 6,
  parameter int unsigned GAP_PERIODS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [DIV_W-1:0]            clkDiv,
  input  logic [$clog2(DATA_W+1)-1:0] bitCount,
  input  logic                        sdi,
  output logic                        csN,
  output logic                        sclk,
  output logic                        busy,
  output logic [DATA_W-1:0]           result,
  output logic [$clog2(DATA_W+1)-1:0] resultBits,
  output logic                        nullErr,
  output logic                        resultValid
);

  rdStrobe_t strb;

  adc_rd_ctrl #(
    .DIV_W(DIV_W), .DATA_W(DATA_W),
    .LEAD_EDGES(LEAD_EDGES), .GAP_PERIODS(GAP_PERIODS)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clkDiv(clkDiv),
    .bitCount(bitCount), .csN(csN), .sclk(sclk), .busy(busy),
    .bitsUsed(resultBits), .strb(strb)
  );

  adc_rd_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .strb(strb),
    .result(result), .nullErr(nullErr), .resultValid(resultValid)
  );

  AST_VALID_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csN) |-> resultValid); // R8

endmodule

// File: tb/adc_serial_reader_tb.sv
module adc_serial_reader_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  clkDiv = 4'd1;
  logic [4:0]  bitCount = 5'd16;
  logic        sdi = 1'b1;
  logic        csN, sclk, busy, nullErr, resultValid;
  logic [15:0] result;
  logic [4:0]  resultBits;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  adc_serial_reader #(.DIV_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clkDiv(clkDiv),
    .bitCount(bitCount), .sdi(sdi), .csN(csN), .sclk(sclk), .busy(busy),
    .result(result), .resultBits(resultBits), .nullErr(nullErr),
    .resultValid(resultValid)
  );

  // Converter model: drives on falling sclk edges
  logic [15:0] modelWord = 16'h0;
  logic        modelNull = 1'b0;
  int          fallN = 0;

  always @(negedge sclk or posedge csN) begin
    if (csN) begin
      fallN = 0;
      sdi   = 1'b1;
    end else begin
      fallN = fallN + 1;
      if (fallN == 5)                     sdi = modelNull;
      else if (fallN >= 6 && fallN <= 21) sdi = modelWord[21 - fallN];
      else if (fallN > 21)                sdi = 1'b0;
    end
  end

  // Monitor, sampling on falling system-clock edges
  logic statClr = 1'b0;
  int   rises, lowBeforeRise, highMin, highMax, runLen, csLowLen;
  int   validCnt, busyLen, csFallCnt;
  logic validAtRise, prevCs, prevSclk;
  logic [15:0] capResult;
  logic [4:0]  capBits;
  logic        capNull;

  always @(negedge clk) begin
    if (statClr) begin
      rises = 0; lowBeforeRise = 0; highMin = 1000; highMax = 0; runLen = 0;
      csLowLen = 0; validCnt = 0; busyLen = 0; csFallCnt = 0; validAtRise = 1'b0;
    end else begin
      if (busy) busyLen++;
      if (prevCs && !csN) csFallCnt++;
      if (!csN) begin
        csLowLen++;
        if (sclk && !prevSclk) rises++;
        if (rises == 0 && !sclk) lowBeforeRise++;
      end
      if (sclk == prevSclk) runLen++;
      else begin
        if (prevSclk) begin
          if (runLen < highMin) highMin = runLen;
          if (runLen > highMax) highMax = runLen;
        end
        runLen = 1;
      end
      if (resultValid) begin
        validCnt++;
        validAtRise = csN && !prevCs;
        capResult = result; capBits = resultBits; capNull = nullErr;
      end
    end
    prevCs = csN;
    prevSclk = sclk;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runFrame(input logic [15:0] word, input logic nul,
                          input int div, input int n, input bit inject);
    int effN, effDiv, cyc;
    bit injMid, injGap;
    logic [15:0] expWord;
    effN   = (n == 0) ? 1 : ((n > 16) ? 16 : n);
    effDiv = (div == 0) ? 1 : div;
    expWord = word & (16'hFFFF << (16 - effN));
    modelWord = word; modelNull = nul;
    @(posedge clk); #1;
    clkDiv = div[3:0]; bitCount = n[4:0]; statClr = 1'b1;
    @(posedge clk); #1;
    statClr = 1'b0; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 0; injMid = 0; injGap = 0;
    while (busy && cyc < 2000) begin
      @(posedge clk); #1;
      start = 1'b0;
      if (inject && !injMid && cyc == 7) begin start = 1'b1; injMid = 1; end
      if (inject && !injGap && validCnt > 0) begin start = 1'b1; injGap = 1; end
      cyc++;
    end
    start = 1'b0;
    repeat (3 + (inject ? 20 : 0)) @(posedge clk);
    #1;
    check("R4 R7 result", capResult, expWord);
    check("R7 resultBits", capBits, effN);
    check("R5 nullErr", capNull, nul);
    check("R6 rising edges with select low", rises, 6 + effN);
    check("R6 select low length", csLowLen, 2 * effDiv * (6 + effN));
    check("R3 low phase before first rise", lowBeforeRise, effDiv);
    check("R2 shortest high phase", highMin, effDiv);
    check("R2 longest high phase", highMax, effDiv);
    check("R8 valid pulse width", validCnt, 1);
    check("R8 valid at select rise", validAtRise, 1);
    check("R9 busy length", busyLen, 2 * effDiv * (8 + effN));
    check("R10 select falls once", csFallCnt, 1);
    check("R9 idle select high", csN, 1);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset csN", csN, 1);
    check("R1 reset sclk", sclk, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset valid", resultValid, 0);
    check("R1 reset nullErr", nullErr, 0);
    check("R1 reset result", result, 0);
    rst_n = 1'b1;
    runFrame(16'h1234, 1'b0, 2, 16, 0);   // R4 full frame, R9 24 periods
    runFrame(16'h8001, 1'b0, 1, 16, 0);   // R4 negative code, minimum divider
    runFrame(16'hFFFF, 1'b1, 3, 16, 0);   // R5 null read high
    runFrame(16'h5A5A, 1'b0, 2, 16, 0);   // R5 error clears on next frame
    runFrame(16'hABCD, 1'b0, 2, 14, 0);   // R7 short read of 14
    runFrame(16'h7FFF, 1'b0, 1, 3, 0);    // R7 short read of 3
    runFrame(16'h8000, 1'b0, 2, 0, 0);    // R6 count 0 clamps to 1
    runFrame(16'hC3A5, 1'b0, 1, 20, 0);   // R6 count 20 clamps to 16
    runFrame(16'h0F0F, 1'b0, 0, 16, 0);   // R2 divider 0 acts as 1
    runFrame(16'h9876, 1'b0, 15, 16, 0);  // R2 maximum divider
    runFrame(16'h2468, 1'b0, 2, 16, 1);   // R10 starts while busy
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule